// File: doc/BRIEF.md
# LCD Horizontal Line Timing Generator

This block produces the horizontal timing of each scan line for a raster LCD panel. A reference clock is divided down to a panel pixel period. Each line is walked through four phases in a fixed order: the line pulse, a back porch, the visible pixels and a front porch. Along the way the block drives a line-clock / horizontal-sync level, a data-enable level, a one-cycle strobe per visible pixel, and a one-cycle request for fresh line data at the first cycle of every line.

Software programs the sync width and the line length through one 32-bit timing word. The porch widths, the divisor field and the passive/active panel selection arrive on plain inputs. All settings are captured at the first cycle of a line, so a line already in progress always finishes with the settings it began with. Vertical timing, pixel packing, the data FIFO and dual-panel splitting belong to neighbouring blocks.

Top module: `lcdLineTiming`

## Requirements
- R1: The timing word stores the sync-width field in bits 15:8 and the line-length field in bits 7:2. Reads return those two fields at the same positions and zero in every other bit. Both fields are zero after reset.
- R2: When the divisor field is P, one panel period lasts P+2 reference cycles. `panelClk` is low for the first floor((P+2)/2) cycles of each period and high for the rest.
- R3: `lineClk` is high from the first cycle of a line for (S+1) panel periods, where S is the effective sync-width field.
- R4: A line holds 16×(L+1) visible pixels, where L is the 6-bit line-length field. `dataEn` is high only while those pixels are shown.
- R5: The phases run in the order line pulse, back porch, visible, front porch, then back to the line pulse. The back porch lasts (B+1) panel periods and the front porch (F+1) panel periods, where B and F are the porch inputs.
- R6: `pixStrobe` is a one-cycle pulse in the last reference cycle of each visible panel period, and it is never high outside the visible phase.
- R7: `lineReq` is high for exactly the first reference cycle of each line, together with `lineClk`.
- R8: In passive mode (`passiveMode`=1), a sync-width field or back-porch input below 2 is treated as 2. In active mode the values are used unchanged.
- R9: A change to the timing word, the porch inputs, the divisor or the mode takes effect only from the next line start.
- R10: While `enable` is low, every output except `regRdData` is low and the counters stay at zero. The first line starts (`lineReq` high) in the cycle after the edge that samples `enable` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | LCD reference clock |
| rstN | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Runs the line sequencer when high |
| passiveMode | input | 1 | 1 = passive panel (minimum clamps apply), 0 = active panel |
| regWrEn | input | 1 | Write strobe for the timing word |
| regWrData | input | 32 | Timing word write data |
| regRdData | output | 32 | Timing word read-back |
| backPorch | input | 8 | Back porch width minus one, in panel periods |
| frontPorch | input | 8 | Front porch width minus one, in panel periods |
| clkDivField | input | 5 | Panel clock divisor field (divide by value + 2) |
| panelClk | output | 1 | Divided panel pixel clock |
| lineClk | output | 1 | Line clock / horizontal sync level |
| dataEn | output | 1 | High during visible pixels |
| pixStrobe | output | 1 | One pulse per visible panel period |
| lineReq | output | 1 | One-cycle line data request |

## Verification
Every output comes from a register one clock edge past its cause. A timing-word write shows on `regRdData` one cycle later. Raising `enable` gives `lineReq` and `lineClk` one cycle later. Inside a line, a phase change happens on the edge that ends the last reference cycle of the phase's last panel period. Settings changed during a line first appear at the next `lineReq`. The bench keeps a behavioural model that is stepped at each rising edge and compared with every output at the falling edge. Separate line-long measurements count sync cycles and pixel strobes between consecutive `lineReq` pulses, so these counts are judged across whole lines rather than at single edges.

// File: rtl/lcdTimingPkg.sv
package lcdTimingPkg;

  // Bit positions of the timing word; neighbouring software decodes these.
  localparam int HSW_LSB = 8;
  localparam int HSW_MSB = 15;
  localparam int PPL_LSB = 2;
  localparam int PPL_MSB = 7;
  localparam int HSW_W   = HSW_MSB - HSW_LSB + 1;
  localparam int PPL_W   = PPL_MSB - PPL_LSB + 1;

  typedef enum logic [2:0] {
    PH_IDLE   = 3'd0,
    PH_SYNC   = 3'd1,
    PH_BACK   = 3'd2,
    PH_ACTIVE = 3'd3,
    PH_FRONT  = 3'd4
  } linePhase_e;

  // Strobes from the sequencer to the counter datapath
  typedef struct packed {
    logic loadShadow;
    logic clrCnt;
    logic incCnt;
  } lineStrobe_t;

endpackage

// File: rtl/lcdTimingReg.sv
module lcdTimingReg
  import lcdTimingPkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [DATA_W-1:0] wrData,
  output logic [HSW_W-1:0]  hswQ,
  output logic [PPL_W-1:0]  pplQ,
  output logic [DATA_W-1:0] rdData
);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      hswQ <= '0;
      pplQ <= '0;
    end else if (wrEn) begin
      hswQ <= wrData[HSW_MSB:HSW_LSB];
      pplQ <= wrData[PPL_MSB:PPL_LSB];
    end
  end

  always_comb begin
    rdData = '0;
    rdData[HSW_MSB:HSW_LSB] = hswQ;
    rdData[PPL_MSB:PPL_LSB] = pplQ;
  end

endmodule

// File: rtl/lcdClkDiv.sv
module lcdClkDiv #(
  parameter int PCD_W = 5
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             run,
  input  logic [PCD_W-1:0] divField,
  output logic             tick,
  output logic             panelClk
);

  localparam int DC_W = PCD_W + 1;

  logic [DC_W-1:0] divCnt;
  logic [DC_W-1:0] divTotal;
  logic [DC_W-1:0] divLast;
  logic [DC_W-1:0] divHalf;

  assign divTotal = DC_W'(divField) + DC_W'(2);
  assign divLast  = DC_W'(divField) + DC_W'(1);
  assign divHalf  = divTotal >> 1;

  assign tick     = run && (divCnt == divLast);
  assign panelClk = run && (divCnt >= divHalf);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)          divCnt <= '0;
    else if (!run)      divCnt <= '0;
    else if (tick)      divCnt <= '0;
    else                divCnt <= divCnt + DC_W'(1);
  end

endmodule

// File: rtl/lcdLineDatapath.sv
module lcdLineDatapath
  import lcdTimingPkg::*;
#(
  parameter int PORCH_W = 8,
  parameter int PCD_W   = 5,
  parameter int MIN_HSW = 2,
  parameter int MIN_HBP = 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  lineStrobe_t        strobe,
  input  linePhase_e         phase,
  input  logic [HSW_W-1:0]   hswReg,
  input  logic [PPL_W-1:0]   pplReg,
  input  logic [PORCH_W-1:0] hbpIn,
  input  logic [PORCH_W-1:0] hfpIn,
  input  logic [PCD_W-1:0]   pcdIn,
  input  logic               passiveIn,
  output logic [PCD_W-1:0]   pcdShadow,
  output logic               cntLast
);

  localparam int ACT_W = PPL_W + 4;
  localparam int WIDE1 = (ACT_W > HSW_W) ? ACT_W : HSW_W;
  localparam int CNT_W = (WIDE1 > PORCH_W) ? WIDE1 : PORCH_W;

  logic [HSW_W-1:0]   hswShadow;
  logic [PPL_W-1:0]   pplShadow;
  logic [PORCH_W-1:0] hbpShadow;
  logic [PORCH_W-1:0] hfpShadow;
  logic [HSW_W-1:0]   hswEff;
  logic [PORCH_W-1:0] hbpEff;
  logic [CNT_W-1:0]   phaseCnt;
  logic [CNT_W-1:0]   phaseLastCnt;

  // Passive panels need a minimum sync and back porch; clamp on capture.
  always_comb begin
    hswEff = hswReg;
    hbpEff = hbpIn;
    if (passiveIn && (hswReg < HSW_W'(MIN_HSW)))  hswEff = HSW_W'(MIN_HSW);
    if (passiveIn && (hbpIn < PORCH_W'(MIN_HBP))) hbpEff = PORCH_W'(MIN_HBP);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      hswShadow <= '0;
      pplShadow <= '0;
      hbpShadow <= '0;
      hfpShadow <= '0;
      pcdShadow <= '0;
    end else if (strobe.loadShadow) begin
      hswShadow <= hswEff;
      pplShadow <= pplReg;
      hbpShadow <= hbpEff;
      hfpShadow <= hfpIn;
      pcdShadow <= pcdIn;
    end
  end

  always_comb begin
    unique case (phase)
      PH_SYNC:   phaseLastCnt = CNT_W'(hswShadow);
      PH_BACK:   phaseLastCnt = CNT_W'(hbpShadow);
      PH_ACTIVE: phaseLastCnt = CNT_W'({pplShadow, 4'hF});
      PH_FRONT:  phaseLastCnt = CNT_W'(hfpShadow);
      default:   phaseLastCnt = '0;
    endcase
  end

  assign cntLast = (phaseCnt == phaseLastCnt);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               phaseCnt <= '0;
    else if (strobe.clrCnt)  phaseCnt <= '0;
    else if (strobe.incCnt)  phaseCnt <= phaseCnt + CNT_W'(1);
  end

endmodule

// File: rtl/lcdLineCtrl.sv
module lcdLineCtrl
  import lcdTimingPkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        enable,
  input  logic        tick,
  input  logic        cntLast,
  output lineStrobe_t strobe,
  output linePhase_e  phase,
  output logic        run,
  output logic        lineReq,
  output logic        lineClk,
  output logic        dataEn,
  output logic        pixStrobe
);

  linePhase_e phaseNext;
  logic       reqNext;

  always_comb begin
    phaseNext = phase;
    reqNext   = 1'b0;
    strobe    = '0;
    if (!enable) begin
      phaseNext     = PH_IDLE;
      strobe.clrCnt = 1'b1;
    end else if (phase == PH_IDLE) begin
      phaseNext         = PH_SYNC;
      strobe.clrCnt     = 1'b1;
      strobe.loadShadow = 1'b1;
      reqNext           = 1'b1;
    end else if (tick) begin
      if (cntLast) begin
        strobe.clrCnt = 1'b1;
        unique case (phase)
          PH_SYNC:   phaseNext = PH_BACK;
          PH_BACK:   phaseNext = PH_ACTIVE;
          PH_ACTIVE: phaseNext = PH_FRONT;
          default: begin
            phaseNext         = PH_SYNC;
            strobe.loadShadow = 1'b1;
            reqNext           = 1'b1;
          end
        endcase
      end else begin
        strobe.incCnt = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phase   <= PH_IDLE;
      lineReq <= 1'b0;
    end else begin
      phase   <= phaseNext;
      lineReq <= reqNext;
    end
  end

  assign run       = (phase != PH_IDLE);
  assign lineClk   = (phase == PH_SYNC);
  assign dataEn    = (phase == PH_ACTIVE);
  assign pixStrobe = dataEn && tick;

endmodule

// File: rtl/lcdLineTiming.sv
module lcdLineTiming
  import lcdTimingPkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int PORCH_W = 8,
  parameter int PCD_W   = 5,
  parameter int MIN_HSW = 2,
  parameter int MIN_HBP = 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               enable,
  input  logic               passiveMode,
  input  logic               regWrEn,
  input  logic [DATA_W-1:0]  regWrData,
  output logic [DATA_W-1:0]  regRdData,
  input  logic [PORCH_W-1:0] backPorch,
  input  logic [PORCH_W-1:0] frontPorch,
  input  logic [PCD_W-1:0]   clkDivField,
  output logic               panelClk,
  output logic               lineClk,
  output logic               dataEn,
  output logic               pixStrobe,
  output logic               lineReq
);

  logic [HSW_W-1:0] hswQ;
  logic [PPL_W-1:0] pplQ;
  logic [PCD_W-1:0] pcdShadow;
  logic             tick;
  logic             run;
  logic             cntLast;
  lineStrobe_t      strobe;
  linePhase_e       phase;

  lcdTimingReg #(.DATA_W(DATA_W)) u_reg (
    .clk(clk), .rstN(rstN), .wrEn(regWrEn), .wrData(regWrData),
    .hswQ(hswQ), .pplQ(pplQ), .rdData(regRdData)
  );

  lcdClkDiv #(.PCD_W(PCD_W)) u_div (
    .clk(clk), .rstN(rstN), .run(run), .divField(pcdShadow),
    .tick(tick), .panelClk(panelClk)
  );

  lcdLineDatapath #(
    .PORCH_W(PORCH_W), .PCD_W(PCD_W), .MIN_HSW(MIN_HSW), .MIN_HBP(MIN_HBP)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .phase(phase),
    .hswReg(hswQ), .pplReg(pplQ), .hbpIn(backPorch), .hfpIn(frontPorch),
    .pcdIn(clkDivField), .passiveIn(passiveMode),
    .pcdShadow(pcdShadow), .cntLast(cntLast)
  );

  lcdLineCtrl u_ctrl (
    .clk(clk), .rstN(rstN), .enable(enable), .tick(tick), .cntLast(cntLast),
    .strobe(strobe), .phase(phase), .run(run), .lineReq(lineReq),
    .lineClk(lineClk), .dataEn(dataEn), .pixStrobe(pixStrobe)
  );

endmodule

// File: rtl/lcdLineTiming_chk.sv
module lcdLineTiming_chk #(
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rstN,
  input logic              enable,
  input logic              regWrEn,
  input logic [DATA_W-1:0] regWrData,
  input logic [DATA_W-1:0] regRdData,
  input logic              panelClk,
  input logic              lineClk,
  input logic              dataEn,
  input logic              pixStrobe,
  input logic              lineReq
);

  assert_req_in_sync_R7: assert property (@(posedge clk) disable iff (!rstN)
    lineReq |-> lineClk);

  assert_req_single_R7: assert property (@(posedge clk) disable iff (!rstN)
    lineReq |=> !lineReq);

  assert_de_not_sync_R4: assert property (@(posedge clk) disable iff (!rstN)
    !(dataEn && lineClk));

  assert_strobe_in_active_R6: assert property (@(posedge clk) disable iff (!rstN)
    pixStrobe |-> dataEn);

  assert_strobe_single_R6: assert property (@(posedge clk) disable iff (!rstN)
    pixStrobe |=> !pixStrobe);

  assert_idle_quiet_R10: assert property (@(posedge clk) disable iff (!rstN)
    !enable |=> (!lineClk && !dataEn && !lineReq && !panelClk && !pixStrobe));

  assert_reg_write_R1: assert property (@(posedge clk) disable iff (!rstN)
    regWrEn |=> (regRdData[15:2] == $past(regWrData[15:2])));

endmodule

bind lcdLineTiming lcdLineTiming_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rstN(rstN), .enable(enable), .regWrEn(regWrEn),
  .regWrData(regWrData), .regRdData(regRdData), .panelClk(panelClk),
  .lineClk(lineClk), .dataEn(dataEn), .pixStrobe(pixStrobe), .lineReq(lineReq)
);

// File: tb/lcdLineTiming_tb.sv
`timescale 1ns/1ps
module lcdLineTiming_tb;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        enable = 1'b0;
  logic        passiveMode = 1'b0;
  logic        regWrEn = 1'b0;
  logic [31:0] regWrData = '0;
  logic [31:0] regRdData;
  logic [7:0]  backPorch = '0;
  logic [7:0]  frontPorch = '0;
  logic [4:0]  clkDivField = '0;
  logic        panelClk, lineClk, dataEn, pixStrobe, lineReq;

  int checks = 0;
  int failures = 0;
  int cyc = 0;
  bit done = 0;
  bit cmpOn = 0;

  always #2 clk = ~clk;

  lcdLineTiming u_dut (
    .clk(clk), .rstN(rstN), .enable(enable), .passiveMode(passiveMode),
    .regWrEn(regWrEn), .regWrData(regWrData), .regRdData(regRdData),
    .backPorch(backPorch), .frontPorch(frontPorch), .clkDivField(clkDivField),
    .panelClk(panelClk), .lineClk(lineClk), .dataEn(dataEn),
    .pixStrobe(pixStrobe), .lineReq(lineReq)
  );

  task automatic check(input string tag, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // Behavioural reference: phase 0 idle, 1 sync, 2 back, 3 visible, 4 front
  int mPhase = 0, mCnt = 0, mDiv = 0, mReq = 0;
  int mHsw = 0, mPpl = 0;
  int sHsw = 0, sPpl = 0, sHbp = 0, sHfp = 0, sPcd = 0;

  function automatic int phaseLen(input int ph);
    case (ph)
      1: return sHsw + 1;
      2: return sHbp + 1;
      3: return 16 * (sPpl + 1);
      default: return sHfp + 1;
    endcase
  endfunction

  task automatic captureLine();
    sHsw = mHsw; sHbp = backPorch;
    if (passiveMode && sHsw < 2) sHsw = 2;
    if (passiveMode && sHbp < 2) sHbp = 2;
    sPpl = mPpl; sHfp = frontPorch; sPcd = clkDivField;
    mPhase = 1; mCnt = 0; mDiv = 0; mReq = 1;
  endtask

  always @(posedge clk) begin
    if (!rstN) begin
      mPhase = 0; mCnt = 0; mDiv = 0; mReq = 0; mHsw = 0; mPpl = 0;
      sHsw = 0; sPpl = 0; sHbp = 0; sHfp = 0; sPcd = 0;
    end else begin
      if (!enable) begin
        mPhase = 0; mCnt = 0; mDiv = 0; mReq = 0;
      end else if (mPhase == 0) begin
        captureLine();
      end else begin
        mReq = 0;
        if (mDiv == sPcd + 1) begin
          mDiv = 0;
          if (mCnt == phaseLen(mPhase) - 1) begin
            mCnt = 0;
            if (mPhase == 4) captureLine();
            else mPhase = mPhase + 1;
          end else mCnt = mCnt + 1;
        end else mDiv = mDiv + 1;
      end
      if (regWrEn) begin
        mHsw = regWrData[15:8];
        mPpl = regWrData[7:2];
      end
    end
  end

  always @(negedge clk) begin
    if (cmpOn) begin
      check("R3 lineClk", lineClk, mPhase == 1);
      check("R4 dataEn", dataEn, mPhase == 3);
      check("R6 pixStrobe", pixStrobe, (mPhase == 3) && (mDiv == sPcd + 1));
      check("R7 lineReq", lineReq, mReq);
      check("R2 panelClk", panelClk, (mPhase != 0) && (mDiv >= (sPcd + 2) / 2));
      check("R1 regRdData", regRdData, (mHsw << 8) | (mPpl << 2));
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !done) begin
      done = 1;
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  task automatic writeReg(input logic [31:0] d);
    @(negedge clk); #1;
    regWrEn = 1'b1; regWrData = d;
    @(negedge clk); #1;
    regWrEn = 1'b0;
  endtask

  // Counts one whole line, from one lineReq to the next.
  task automatic measureLine(input int expSync, input int expPix, input string tag,
                             input bit doWr, input logic [31:0] wrData);
    int syncN = 0;
    int pixN = 0;
    int deN = 0;
    bit first = 1;
    do @(negedge clk); while (!lineReq);
    while (1) begin
      if (lineClk) syncN++;
      if (pixStrobe) pixN++;
      if (dataEn) deN++;
      #1;
      if (first && doWr) begin regWrEn = 1'b1; regWrData = wrData; end
      else regWrEn = 1'b0;
      first = 0;
      @(negedge clk);
      if (lineReq) break;
    end
    check({tag, " sync cycles R3"}, syncN, expSync);
    check({tag, " pixel strobes R4"}, pixN, expPix);
    check({tag, " R6 one strobe per visible period"}, deN, expPix * (clkDivField + 2));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    cmpOn = 1;
    check("R1 reset read", regRdData, 0);
    check("R10 reset lineClk", lineClk, 0);

    // R1: reserved and upper bits are dropped
    writeReg(32'hFFFF_AB07);
    @(negedge clk);
    check("R1 readback", regRdData, 32'h0000_AB04);
    writeReg(32'hFFFF_0003);
    @(negedge clk);
    check("R1 reserved zero", regRdData, 0);

    // R8: passive clamp of sync and back porch, divide by 2
    passiveMode = 1; backPorch = 0; frontPorch = 1; clkDivField = 0;
    @(negedge clk); #1; enable = 1'b1;
    @(negedge clk);
    check("R10 first lineReq", lineReq, 1);
    measureLine(6, 16, "R8 passive clamp", 0, 0);

    // R8: active mode uses the raw field (applies from the next line, R9)
    #1; passiveMode = 0;
    measureLine(2, 16, "R8 active unclamped", 0, 0);

    // R9: divisor change and a register write inside a line
    #1; clkDivField = 5; backPorch = 3; frontPorch = 2;
    measureLine(7, 16, "R9 old settings hold", 1, 32'h0000_0408);
    measureLine(35, 48, "R9 new settings", 0, 0);

    // R4: longest line, R8 clamp of sync field 1
    #1; clkDivField = 0; passiveMode = 1; backPorch = 1;
    writeReg(32'h0000_01FC);
    measureLine(6, 1024, "R4 full length", 0, 0);

    // R10: disable in the middle of a line
    do @(negedge clk); while (!dataEn);
    #1; enable = 1'b0;
    repeat (3) @(negedge clk);
    check("R10 off lineClk", lineClk, 0);
    check("R10 off dataEn", dataEn, 0);
    check("R10 off panelClk", panelClk, 0);
    #1; enable = 1'b1;
    @(negedge clk);
    check("R10 restart lineReq", lineReq, 1);
    check("R7 restart lineClk", lineClk, 1);
    measureLine(6, 1024, "R5 after restart", 0, 0);

    repeat (5) @(negedge clk);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule